// File: doc/BRIEF.md
# LCD Contrast PWM Generator

This block produces one pulse-width-modulated output for driving the contrast input or the backlight of a display panel. Software programs it through a small register file with two words: an 8-bit duty value and a control word. The control word selects a clock prescaler, an output polarity and an enable. The input clock is divided by 1, 2, 4 or 8. Each divided tick advances an 8-bit period counter, and the output is active while that counter is below the duty value.

A duty write goes into a shadow register that reads back at once. The comparator only takes the new value when the period counter wraps, so a pulse is never cut short or stretched mid-period. Clearing the enable bit stops both counters at zero and parks the output at its inactive level. A duty of zero with the enable set also gives a constant inactive output, so either one turns the panel drive off.

Top module: `lcd_contrast_pwm`

## Requirements
- R1: Out of reset the duty word reads 0xC8 and the control word reads 0x0B (divide by 8, normal polarity, enabled). The output is low while reset is held.
- R2: Address 0 is the duty word. A read returns the last value written, straight after the write. Address 1 is the control word: bits 1:0 are the prescaler select, bit 2 inverts the output, bit 3 enables the PWM, and bits 7:4 are ignored on write and read as zero. A write to one address leaves the other unchanged.
- R3: A prescaler select of 0, 1, 2 or 3 divides the clock by 1, 2, 4 or 8. One PWM period is 256 times the divisor in clock cycles.
- R4: With bit 2 clear, the output is high for duty × divisor cycles of each period and low for the rest.
- R5: With bit 2 set, the output is the complement: it is high for (256 − duty) × divisor cycles of each period.
- R6: With the PWM enabled, a duty of 0 keeps the output constantly inactive. A duty of 255 gives 255 × divisor active cycles out of 256 × divisor.
- R7: A new duty value takes effect only at the wrap of the PWM period, so every active pulse has the full width of either the old or the new duty.
- R8: With bit 3 clear, the counters are held at zero and the output stays at the inactive level: low for normal polarity, high for inverted. Writing 0 to the control word therefore gives a constant low output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 duty, 1 control |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register (combinational) |
| pwmOut | output | 1 | Registered PWM output |

## Verification
The bench builds the block with its default parameters: an 8-bit duty, a 2-bit prescaler select and the reset values above. With these, the longest period is 2048 cycles. That is short enough to measure an exact active-cycle count over one whole period at every divisor, and at the duty extremes 0, 1 and 255, in both polarities. A run-length monitor watches the output across a duty change written mid-period, which tests that the new value is held back until the wrap.

// File: rtl/lcd_contrast_pwm_pkg.sv
package lcd_contrast_pwm_pkg;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic run;     // PWM enabled
    logic step;    // prescaled tick: advance the period counter
    logic invert;  // active-low output
  } pwm_strobe_t;

  localparam logic ADDR_DUTY = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

endpackage

// File: rtl/lcd_contrast_pwm_ctl.sv
module lcd_contrast_pwm_ctl
  import lcd_contrast_pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int SEL_W = 2,
  parameter logic [DUTY_W-1:0] RESET_DUTY = 8'hC8,
  parameter logic [SEL_W-1:0] RESET_SEL = 2'd3,
  parameter logic RESET_INV = 1'b0,
  parameter logic RESET_EN = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic regAddr,
  input  logic [DUTY_W-1:0] regWrData,
  output logic [DUTY_W-1:0] regRdData,
  output logic [DUTY_W-1:0] dutyShadow,
  output pwm_strobe_t stb
);

  localparam int MAX_SHIFT = (1 << SEL_W) - 1;
  localparam int DIV_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;
  localparam int INV_BIT = SEL_W;
  localparam int EN_BIT = SEL_W + 1;

  logic [SEL_W-1:0] selQ;
  logic invQ;
  logic enQ;
  logic [DUTY_W-1:0] dutyQ;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic wrDuty;
  logic wrCtrl;
  logic tick;

  assign wrDuty = regWrEn && (regAddr == ADDR_DUTY);
  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);

  // Register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyQ <= RESET_DUTY;
      selQ <= RESET_SEL;
      invQ <= RESET_INV;
      enQ <= RESET_EN;
    end else begin
      if (wrDuty) dutyQ <= regWrData;
      if (wrCtrl) begin
        selQ <= regWrData[SEL_W-1:0];
        invQ <= regWrData[INV_BIT];
        enQ <= regWrData[EN_BIT];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_DUTY) begin
      regRdData = dutyQ;
    end else begin
      regRdData[SEL_W-1:0] = selQ;
      regRdData[INV_BIT] = invQ;
      regRdData[EN_BIT] = enQ;
    end
  end

  // Terminal count of the prescaler: divisor-1 is 'selQ' ones
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      divLimit[i] = (i < int'(selQ));
    end
  end

  // >= so that a smaller divisor chosen mid-count recovers at once
  assign tick = enQ && (divCnt >= divLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!enQ || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign dutyShadow = dutyQ;
  assign stb.run = enQ;
  assign stb.step = tick;
  assign stb.invert = invQ;

endmodule

// File: rtl/lcd_contrast_pwm_dp.sv
module lcd_contrast_pwm_dp
  import lcd_contrast_pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter logic [DUTY_W-1:0] RESET_DUTY = 8'hC8,
  parameter logic RESET_INV = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  pwm_strobe_t stb,
  input  logic [DUTY_W-1:0] dutyShadow,
  output logic [DUTY_W-1:0] pwmCount,
  output logic [DUTY_W-1:0] dutyLive,
  output logic pwmOut
);

  localparam logic [DUTY_W-1:0] CNT_MAX = '1;

  logic [DUTY_W-1:0] cntQ;
  logic [DUTY_W-1:0] liveQ;
  logic outQ;
  logic atWrap;
  logic activePhase;

  assign atWrap = stb.step && (cntQ == CNT_MAX);
  assign activePhase = cntQ < liveQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (!stb.run) begin
      cntQ <= '0;
    end else if (stb.step) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  // Compare value follows the shadow only at a period boundary or when idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveQ <= RESET_DUTY;
    end else if (!stb.run || atWrap) begin
      liveQ <= dutyShadow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ <= RESET_INV;
    end else if (!stb.run) begin
      outQ <= stb.invert;
    end else begin
      outQ <= activePhase ^ stb.invert;
    end
  end

  assign pwmCount = cntQ;
  assign dutyLive = liveQ;
  assign pwmOut = outQ;

endmodule

// File: rtl/lcd_contrast_pwm.sv
module lcd_contrast_pwm
  import lcd_contrast_pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int SEL_W = 2,
  parameter logic [DUTY_W-1:0] RESET_DUTY = 8'hC8,
  parameter logic [SEL_W-1:0] RESET_SEL = 2'd3,
  parameter logic RESET_INV = 1'b0,
  parameter logic RESET_EN = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic regAddr,
  input  logic [DUTY_W-1:0] regWrData,
  output logic [DUTY_W-1:0] regRdData,
  output logic pwmOut
);

  pwm_strobe_t stb;
  logic [DUTY_W-1:0] dutyShadow;
  logic [DUTY_W-1:0] pwmCount;
  logic [DUTY_W-1:0] dutyLive;
  logic stbRun;
  logic stbStep;
  logic stbInvert;

  lcd_contrast_pwm_ctl #(
    .DUTY_W(DUTY_W), .SEL_W(SEL_W), .RESET_DUTY(RESET_DUTY),
    .RESET_SEL(RESET_SEL), .RESET_INV(RESET_INV), .RESET_EN(RESET_EN)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .dutyShadow(dutyShadow), .stb(stb)
  );

  lcd_contrast_pwm_dp #(
    .DUTY_W(DUTY_W), .RESET_DUTY(RESET_DUTY), .RESET_INV(RESET_INV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dutyShadow(dutyShadow),
    .pwmCount(pwmCount), .dutyLive(dutyLive), .pwmOut(pwmOut)
  );

  assign stbRun = stb.run;
  assign stbStep = stb.step;
  assign stbInvert = stb.invert;

endmodule

// File: rtl/lcd_contrast_pwm_chk.sv
module lcd_contrast_pwm_chk #(
  parameter int DUTY_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic pwmOut,
  input logic run,
  input logic step,
  input logic invert,
  input logic [DUTY_W-1:0] pwmCount,
  input logic [DUTY_W-1:0] dutyLive
);

  // R8: disabled drives the inactive level on the next clock
  p_off_inactive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(run) |-> (pwmOut == $past(invert)));

  // R8: counter parked at zero while disabled
  p_off_cnt_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (pwmCount == '0));

  // R6: zero duty never produces an active level
  p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(run) && ($past(dutyLive) == '0)) |-> (pwmOut == $past(invert)));

  // R7: compare value moves only at wrap or while idle
  p_duty_at_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dutyLive) |-> (!$past(run) || ($past(step) && ($past(pwmCount) == '1))));

  // R3: the period counter moves only on a prescaled tick
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && !$past(step)) |-> $stable(pwmCount));

  // R3: and then by exactly one, modulo the counter width
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && $past(step)) |-> (pwmCount == DUTY_W'($past(pwmCount) + 1)));

endmodule

bind lcd_contrast_pwm lcd_contrast_pwm_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .run(stbRun), .step(stbStep),
  .invert(stbInvert), .pwmCount(pwmCount), .dutyLive(dutyLive)
);

// File: tb/sim_lcd_contrast_pwm.sv
module sim_lcd_contrast_pwm;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic pwmOut;

  int checkCnt = 0;
  int failCnt = 0;

  typedef struct {
    int kind;    // 0: active-cycle count, 1: allowed pulse widths
    int window;
    int expA;
    int expB;
    string req;
  } item_t;

  item_t q[$];

  always #2 clk = ~clk;

  lcd_contrast_pwm u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic addr, input logic [7:0] data);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic addr, input int exp, input string req);
    @(posedge clk); #1;
    regAddr = addr;
    @(negedge clk);
    check(regRdData == exp[7:0], req, int'(regRdData), exp);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Driver: push an expected item and wait for the monitor to consume it
  task automatic expectCount(input int window, input int exp, input string req);
    item_t it;
    it.kind = 0; it.window = window; it.expA = exp; it.expB = exp; it.req = req;
    q.push_back(it);
    while (q.size() != 0) @(posedge clk);
  endtask

  // Monitor
  initial begin
    forever begin
      item_t it;
      int act;
      int runLen;
      int bad;
      int runs;
      logic prev;
      bit armed;
      while (q.size() == 0) @(negedge clk);
      it = q[0];
      act = 0; runLen = 0; bad = 0; runs = 0; armed = 0;
      prev = pwmOut;
      for (int c = 0; c < it.window; c++) begin
        @(negedge clk);
        if (pwmOut) act++;
        if (pwmOut && !prev) begin
          armed = 1; runLen = 1;
        end else if (pwmOut && armed) begin
          runLen++;
        end else if (!pwmOut && prev && armed) begin
          runs++;
          if (runLen != it.expA && runLen != it.expB) begin
            bad++;
            $display("FAIL %s: pulse width actual %0d expected %0d or %0d",
                     it.req, runLen, it.expA, it.expB);
          end
        end
        prev = pwmOut;
      end
      if (it.kind == 0) check(act == it.expA, it.req, act, it.expA);
      else check((bad == 0) && (runs >= 2), it.req, runs, 2);
      void'(q.pop_front());
    end
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    item_t rt;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(pwmOut == 1'b0, "R1 output low in reset", int'(pwmOut), 0);
    #1 rstN = 1'b1;

    // R1: reset values
    readCheck(1'b0, 8'hC8, "R1 duty reset");
    readCheck(1'b1, 8'h0B, "R1 control reset");
    waitCycles(20);
    expectCount(2048, 200 * 8, "R1 R4 default 0xC8 at /8");

    // R3 R4: divide by 1
    writeReg(1'b0, 8'h40);
    writeReg(1'b1, 8'h08);
    waitCycles(4300);
    expectCount(256, 64, "R3 R4 duty 0x40 at /1");

    // R3 R4: divide by 2, duty 1
    writeReg(1'b0, 8'h01);
    writeReg(1'b1, 8'h09);
    waitCycles(4300);
    expectCount(512, 2, "R3 R4 duty 1 at /2");

    // R6: duty 255 at /4
    writeReg(1'b0, 8'hFF);
    writeReg(1'b1, 8'h0A);
    waitCycles(4300);
    expectCount(1024, 255 * 4, "R6 duty 255 at /4");

    // R6: duty 0 enabled
    writeReg(1'b0, 8'h00);
    writeReg(1'b1, 8'h08);
    waitCycles(4300);
    expectCount(256, 0, "R6 duty 0 enabled");

    // R5: inverted polarity
    writeReg(1'b0, 8'h40);
    writeReg(1'b1, 8'h0C);
    waitCycles(4300);
    expectCount(256, 192, "R5 inverted duty 0x40");

    // R8: disabled, inverted holds high
    writeReg(1'b1, 8'h04);
    waitCycles(5);
    expectCount(256, 256, "R8 disabled inverted high");

    // R8: control written 0 holds low, duty write has no effect
    writeReg(1'b1, 8'h00);
    writeReg(1'b0, 8'h80);
    waitCycles(5);
    expectCount(256, 0, "R8 control zero low");

    // R2: upper control bits ignored, cross-address isolation
    writeReg(1'b1, 8'hF9);
    readCheck(1'b1, 8'h09, "R2 control upper bits read zero");
    writeReg(1'b0, 8'h5A);
    readCheck(1'b0, 8'h5A, "R2 duty readback immediate");
    readCheck(1'b1, 8'h09, "R2 control unchanged by duty write");

    // R7: mid-period duty change produces only full pulses
    writeReg(1'b0, 8'h40);
    writeReg(1'b1, 8'h08);
    waitCycles(4300);
    rt.kind = 1; rt.window = 1024; rt.expA = 64; rt.expB = 128;
    rt.req = "R7 duty change at wrap";
    q.push_back(rt);
    waitCycles(100);
    writeReg(1'b0, 8'h80);
    while (q.size() != 0) @(posedge clk);
    waitCycles(600);
    expectCount(256, 128, "R7 new duty in force after wrap");

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule